// File: doc/BRIEF.md
# Power-Up and Command Reset Sequencer

This block owns the start-up of a multi-channel controller. An asynchronous active-low reset pin is brought into the clock domain through a synchronizer. It is then screened by a minimum-width filter, so that a glitch cannot restart the device. A low level that lasts long enough places the controller in a hold phase. When the pin returns high, a timed initialization phase of fixed length follows. After it the controller settles in idle. The host learns that start-up is complete by reading the global status vector: it reads all ones in idle and a busy code at every other time.

The host can also restart every channel in software. It writes the channel command register with bit 7 and bit 0 both set. That command enters the same hold-then-initialize path as the pin does. Every other host write is passed on to the channel configuration logic, but only while the block is idle. During hold and initialization, all writes are dropped and every per-channel reset line is held active. The initialization length is a parameter in clock cycles. Elaboration rejects any value that would exceed 500 microseconds at the stated clock rate.

Top module: `rst_seq_top`

## Requirements
- R1: A low level on `rst_pin_n` seen on at least MIN_LOW (default 5) consecutive rising clock edges puts the block in the hold phase: `in_reset_o`=1, `ready_o`=0.
- R2: A low pulse on `rst_pin_n` shorter than MIN_LOW clock periods, applied while idle, has no effect: `ready_o` stays 1.
- R3: The pin passes through SYNC_STAGES (default 2) flip-flops, so for a pulse that starts just before edge 1, `ready_o` stays 1 through edge SYNC_STAGES+MIN_LOW and reads 0 after edge SYNC_STAGES+MIN_LOW+1.
- R4: After the pin rises just before edge 1, `ready_o` first reads 1 after edge SYNC_STAGES+2+INIT_CYCLES; initialization lasts exactly INIT_CYCLES cycles.
- R5: `gsv_o` reads 8'hFF exactly when `ready_o`=1, and reads the busy code GSV_BUSY (default 8'h00) otherwise.
- R6: In idle, a write to address CCR_ADDR (default 7'h11) with data bit 7 and bit 0 both 1 drops `ready_o` after that edge. `ready_o` returns to 1 after edge INIT_CYCLES+2, counting the write edge as edge 1.
- R7: A write to CCR_ADDR with only one of bits 7 and 0 set causes no reset and is forwarded as a configuration write.
- R8: While `ready_o`=0, `cfg_we_o` is 0 for every host write, and a software reset command issued then neither restarts nor extends initialization.
- R9: `chan_rst_o` is all ones whenever `ready_o`=0 and all zeros whenever `ready_o`=1.
- R10: In idle, a host write that is not a software reset command raises `cfg_we_o` in the same cycle, with `cfg_addr_o` and `cfg_wdata_o` equal to the host address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 8 | Host write data |
| in_reset_o | output | 1 | High during the hold phase |
| ready_o | output | 1 | High in idle, after initialization is complete |
| gsv_o | output | 8 | Global status vector: 8'hFF in idle, GSV_BUSY otherwise |
| chan_rst_o | output | NCH | Per-channel reset, active high |
| cfg_we_o | output | 1 | Write enable forwarded to channel configuration |
| cfg_addr_o | output | ADDR_W | Forwarded write address |
| cfg_wdata_o | output | 8 | Forwarded write data |

## Verification
The assertions check the following on every cycle: the status vector, the ready flag and the channel resets agree; writes are suppressed outside idle; a qualified pin reset or a two-bit command enters hold on the next edge, and a one-bit command does not. A counter in the checker also confirms that every initialization phase lasts exactly the configured number of cycles. Some behaviours can only be shown by the bench's scenarios. These are the exact edge on which a pin pulse is recognised after synchronizer latency, the rejection of short glitches of every sub-threshold width, the release-to-ready count, and the faithful forwarding of random write traffic.

// File: rtl/rst_seq_pkg.sv
// Shared types and constants for the reset sequencer.
// Assumes: nothing beyond the parameters of the units that import it.
package rst_seq_pkg;

    // Sequencer phases: hold while reset is applied, timed init, then idle.
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_INIT = 2'd1,
        ST_IDLE = 2'd2
    } seq_state_t;

    // Status vector value that announces completed start-up.
    localparam logic [7:0] GSV_DONE = 8'hFF;

    // Bit positions of the global reset command in the command register.
    localparam int CMD_HI_BIT = 7;
    localparam int CMD_LO_BIT = 0;

endpackage

// File: rtl/rst_pin_sync.sv
// Multi-flop synchronizer for the asynchronous reset pin.
// Assumes: STAGES >= 2. The flops carry no reset, because their own input is
// the reset; they fill with the pin level within STAGES clocks.
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_sync_n
);

    logic [STAGES-1:0] chain;
    logic [STAGES:0]   chain_next;

    assign chain_next = {chain, pin_n};

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        chain <= chain_next[STAGES-1:0];
    end

    assign pin_sync_n = chain[STAGES-1];

endmodule

// File: rtl/rst_width_qual.sv
// Minimum-width filter: asserts a qualified reset once the synchronized pin
// has been sampled low on MIN_LOW consecutive edges, and holds it while low.
// Assumes: MIN_LOW >= 2. Uses a sample window instead of a counter, so it
// needs no reset of its own and settles from power-up within MIN_LOW clocks.
module rst_width_qual #(
    parameter int MIN_LOW = 5
) (
    input  logic clk,
    input  logic pin_sync_n,
    output logic hw_qual
);

    logic [MIN_LOW-2:0] history;
    logic [MIN_LOW-1:0] window;

    assign window = {history, pin_sync_n};

    // Keep the most recent MIN_LOW-1 samples of the synchronized pin.
    always_ff @(posedge clk) begin
        history <= window[MIN_LOW-2:0];
    end

    // Qualify the reset when every sample in the window is low.
    always_ff @(posedge clk) begin
        hw_qual <= ~|window;
    end

endmodule

// File: rtl/rst_seq_fsm.sv
// Phase controller: hold, timed initialization, idle. A qualified pin reset
// acts as its synchronous active-low reset. A software command from idle
// re-enters hold, so both sources share the same start-up path.
// Assumes: INIT_CYCLES >= 1; sw_cmd is only raised by the gate while idle.
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int INIT_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_ok_n,
    input  logic       sw_cmd,
    output seq_state_t state_o
);

    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    seq_state_t      state;
    logic [CNT_W-1:0] init_cnt;

    // Advance the phase and time the initialization window.
    always_ff @(posedge clk) begin
        if (!rst_ok_n) begin
            state    <= ST_HOLD;
            init_cnt <= '0;
        end else begin
            case (state)
                ST_HOLD: begin
                    state    <= ST_INIT;
                    init_cnt <= '0;
                end
                ST_INIT: begin
                    if (init_cnt == CNT_LAST) begin
                        state <= ST_IDLE;
                    end else begin
                        init_cnt <= init_cnt + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (sw_cmd) begin
                        state <= ST_HOLD;
                    end
                end
                default: begin
                    state    <= ST_HOLD;
                    init_cnt <= '0;
                end
            endcase
        end
    end

    assign state_o = state;

endmodule

// File: rtl/rst_write_gate.sv
// Host write screen: decodes the global software reset command and forwards
// every other write to channel configuration, but only while idle.
// Assumes: a write lasts one cycle; the address and data are passed through
// unchanged, and the enable is their only qualifier.
module rst_write_gate
    import rst_seq_pkg::*;
#(
    parameter int              ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] CCR_ADDR = 7'h11
) (
    input  logic              idle,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              sw_cmd,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [7:0]        cfg_wdata
);

    logic hit_cmd_reg;
    logic both_bits;

    // Recognise the two-bit global reset code in the command register.
    always_comb begin
        hit_cmd_reg = (host_addr == CCR_ADDR);
        both_bits   = host_wdata[CMD_HI_BIT] & host_wdata[CMD_LO_BIT];
        sw_cmd      = idle & host_wr & hit_cmd_reg & both_bits;
        cfg_we      = idle & host_wr & ~(hit_cmd_reg & both_bits);
    end

    assign cfg_addr  = host_addr;
    assign cfg_wdata = host_wdata;

endmodule

// File: rtl/rst_seq_top.sv
// Reset sequencer top: synchronizes and width-checks the reset pin, runs the
// start-up phases, publishes the global status vector and drives the
// per-channel resets. Assumes INIT_CYCLES fits the 500 us limit at CLK_HZ.
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int              NCH         = 8,
    parameter int              ADDR_W      = 7,
    parameter int              SYNC_STAGES = 2,
    parameter int              MIN_LOW     = 5,
    parameter int              INIT_CYCLES = 1000,
    parameter int              CLK_HZ      = 100_000_000,
    parameter logic [ADDR_W-1:0] CCR_ADDR  = 7'h11,
    parameter logic [7:0]      GSV_BUSY    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              in_reset_o,
    output logic              ready_o,
    output logic [7:0]        gsv_o,
    output logic [NCH-1:0]    chan_rst_o,
    output logic              cfg_we_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic [7:0]        cfg_wdata_o
);

    // 500 us is one two-thousandth of a second.
    localparam int MAX_INIT = CLK_HZ / 2000;

    if (INIT_CYCLES < 1 || INIT_CYCLES > MAX_INIT) begin : g_init_range
        $error("INIT_CYCLES must lie between 1 and CLK_HZ/2000");
    end

    logic       pin_sync_n;
    logic       hw_qual;
    logic       sw_cmd;
    logic       idle;
    seq_state_t state;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .pin_n      (rst_pin_n),
        .pin_sync_n (pin_sync_n)
    );

    rst_width_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk        (clk),
        .pin_sync_n (pin_sync_n),
        .hw_qual    (hw_qual)
    );

    rst_seq_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_ok_n (~hw_qual),
        .sw_cmd   (sw_cmd),
        .state_o  (state)
    );

    rst_write_gate #(.ADDR_W(ADDR_W), .CCR_ADDR(CCR_ADDR)) u_gate (
        .idle       (idle),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .sw_cmd     (sw_cmd),
        .cfg_we     (cfg_we_o),
        .cfg_addr   (cfg_addr_o),
        .cfg_wdata  (cfg_wdata_o)
    );

    // Decode phase indications for the host and the channels.
    always_comb begin
        idle       = (state == ST_IDLE);
        in_reset_o = (state == ST_HOLD);
        ready_o    = idle;
        gsv_o      = idle ? GSV_DONE : GSV_BUSY;
    end

    // One reset line per channel, all released together at idle.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign chan_rst_o[g] = ~idle;
    end

endmodule

// File: rtl/rst_seq_chk.sv
// Property checker for rst_seq_top, attached by bind. It arms once the hold
// phase has been seen, so the unknown power-up state is never checked.
module rst_seq_chk #(
    parameter int              NCH         = 8,
    parameter int              ADDR_W      = 7,
    parameter int              INIT_CYCLES = 1000,
    parameter logic [ADDR_W-1:0] CCR_ADDR  = 7'h11,
    parameter logic [7:0]      GSV_BUSY    = 8'h00
) (
    input logic              clk,
    input logic              hw_qual,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              in_reset_o,
    input logic              ready_o,
    input logic [7:0]        gsv_o,
    input logic [NCH-1:0]    chan_rst_o,
    input logic              cfg_we_o
);

    localparam int LW = $clog2(INIT_CYCLES + 2);

    logic          armed = 1'b0;
    logic [LW-1:0] busy_cnt;
    logic          cmd_both;
    logic          cmd_one;

    // Arm the properties after the first hold phase.
    always_ff @(posedge clk) begin
        armed <= armed | in_reset_o;
    end

    // Count initialization cycles since the last hold cycle.
    always_ff @(posedge clk) begin
        if (in_reset_o || ready_o) begin
            busy_cnt <= '0;
        end else if (busy_cnt != LW'(INIT_CYCLES + 1)) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assign cmd_both = host_wr && (host_addr == CCR_ADDR) && host_wdata[7] && host_wdata[0];
    assign cmd_one  = host_wr && (host_addr == CCR_ADDR) && (host_wdata[7] ^ host_wdata[0]);

    AST_QUAL_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!armed)
        hw_qual |=> in_reset_o); // R1
    AST_INIT_LENGTH: assert property (@(posedge clk) disable iff (!armed)
        $rose(ready_o) |-> busy_cnt == LW'(INIT_CYCLES)); // R4
    AST_GSV_DONE: assert property (@(posedge clk) disable iff (!armed)
        ready_o |-> gsv_o == 8'hFF); // R5
    AST_GSV_BUSY: assert property (@(posedge clk) disable iff (!armed)
        !ready_o |-> gsv_o == GSV_BUSY); // R5
    AST_SW_RESET: assert property (@(posedge clk) disable iff (!armed)
        (ready_o && cmd_both) |=> in_reset_o); // R6
    AST_ONE_BIT_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!armed)
        (ready_o && cmd_one && !hw_qual) |=> ready_o); // R7
    AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!armed)
        !ready_o |-> !cfg_we_o); // R8
    AST_CHAN_RST_MATCH: assert property (@(posedge clk) disable iff (!armed)
        chan_rst_o == (ready_o ? {NCH{1'b0}} : {NCH{1'b1}})); // R9

endmodule

bind rst_seq_top rst_seq_chk #(
    .NCH         (NCH),
    .ADDR_W      (ADDR_W),
    .INIT_CYCLES (INIT_CYCLES),
    .CCR_ADDR    (CCR_ADDR),
    .GSV_BUSY    (GSV_BUSY)
) u_chk (
    .clk        (clk),
    .hw_qual    (hw_qual),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .in_reset_o (in_reset_o),
    .ready_o    (ready_o),
    .gsv_o      (gsv_o),
    .chan_rst_o (chan_rst_o),
    .cfg_we_o   (cfg_we_o)
);

// File: tb/rst_seq_top_tb.sv
// Bench for rst_seq_top: directed start-up, pulse-width and command cases
// plus seeded random host traffic, checked against computed expectations.
module rst_seq_top_tb;

    localparam int NCH    = 8;
    localparam int AW     = 7;
    localparam int STG    = 2;
    localparam int MINL   = 5;
    localparam int INIT   = 64;
    localparam logic [AW-1:0] CCR  = 7'h11;
    localparam logic [7:0]    BUSY = 8'h00;

    logic          clk = 1'b0;
    logic          rst_pin_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          in_reset_o, ready_o, cfg_we_o;
    logic [7:0]    gsv_o, cfg_wdata_o;
    logic [NCH-1:0] chan_rst_o;
    logic [AW-1:0] cfg_addr_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rst_seq_top #(
        .NCH(NCH), .ADDR_W(AW), .SYNC_STAGES(STG), .MIN_LOW(MINL),
        .INIT_CYCLES(INIT), .CLK_HZ(100_000_000), .CCR_ADDR(CCR), .GSV_BUSY(BUSY)
    ) u_dut (
        .clk(clk), .rst_pin_n(rst_pin_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .in_reset_o(in_reset_o), .ready_o(ready_o),
        .gsv_o(gsv_o), .chan_rst_o(chan_rst_o), .cfg_we_o(cfg_we_o),
        .cfg_addr_o(cfg_addr_o), .cfg_wdata_o(cfg_wdata_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_we(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
        return wr && !(a == CCR && d[7] && d[0]);
    endfunction

    function automatic bit is_glob(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
        return wr && a == CCR && d[7] && d[0];
    endfunction

    // Count edges until ready, starting from a given edge number.
    task automatic wait_ready(input int start_n, output int n);
        n = start_n;
        while (!ready_o && n < 5000) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    // Phase outputs that must agree with the ready flag.
    task automatic check_phase(input string req);
        chk(gsv_o == (ready_o ? 8'hFF : BUSY), {req, " R5 gsv"}, gsv_o, ready_o ? 8'hFF : BUSY);
        chk(chan_rst_o == (ready_o ? '0 : '1), {req, " R9 chan_rst"}, chan_rst_o, ready_o ? 0 : 8'hFF);
    endtask

    // Software reset from idle, optionally with writes injected during init.
    task automatic sw_reset(input bit inject);
        int n;
        @(negedge clk);
        host_wr = 1'b1; host_addr = CCR; host_wdata = 8'h81;
        @(posedge clk); #1;
        chk(ready_o == 1'b0 && in_reset_o == 1'b1, "R6 command enters hold", ready_o, 0);
        host_wr = 1'b0;
        n = 1;
        while (!ready_o && n < 5000) begin
            if (inject && (n == 10 || n == 20)) begin
                host_wr = 1'b1;
                host_addr = (n == 10) ? CCR : 7'h05;
                host_wdata = (n == 10) ? 8'hFF : 8'h3C;
                #2;
                chk(cfg_we_o == 1'b0, "R8 write ignored while busy", cfg_we_o, 0);
                check_phase("R8");
                @(negedge clk); host_wr = 1'b0;
            end
            @(posedge clk); #1;
            n++;
        end
        chk(n == INIT + 2, "R6 sw reset ready edge", n, INIT + 2);
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd2024));

        // Power-up hold with the pin low.
        repeat (12) @(negedge clk);
        chk(in_reset_o == 1'b1 && ready_o == 1'b0, "R1 hold at power-up", in_reset_o, 1);
        check_phase("R1");

        // Release and time the initialization.
        @(negedge clk); rst_pin_n = 1'b1;
        @(posedge clk); #1;
        wait_ready(1, n);
        chk(n == STG + 2 + INIT, "R4 release-to-ready edge", n, STG + 2 + INIT);
        check_phase("R4 idle");
        chk(in_reset_o == 1'b0, "R4 hold cleared", in_reset_o, 0);

        // Software reset with writes attempted while busy.
        sw_reset(1'b1);
        check_phase("R6 idle");

        // One-bit commands are forwarded and do not reset.
        for (int b = 0; b < 2; b++) begin
            @(negedge clk);
            host_wr = 1'b1; host_addr = CCR; host_wdata = b ? 8'h01 : 8'h80;
            #1;
            chk(cfg_we_o == 1'b1 && cfg_wdata_o == host_wdata, "R7 one-bit forwarded", cfg_wdata_o, host_wdata);
            @(posedge clk); #1; host_wr = 1'b0;
            repeat (3) @(posedge clk); #1;
            chk(ready_o == 1'b1, "R7 one-bit no reset", ready_o, 1);
        end

        // Seeded random host traffic in idle.
        for (int k = 0; k < 300; k++) begin
            bit g;
            @(negedge clk);
            host_wr    = ($urandom % 4) != 0;
            host_addr  = (($urandom % 3) == 0) ? CCR : AW'($urandom);
            host_wdata = 8'($urandom);
            if (k % 40 == 7) begin
                host_wr = 1'b1; host_addr = CCR; host_wdata = host_wdata | 8'h81;
            end
            g = is_glob(host_wr, host_addr, host_wdata);
            #1;
            chk(cfg_we_o == exp_we(host_wr, host_addr, host_wdata), "R10 write enable", cfg_we_o,
                exp_we(host_wr, host_addr, host_wdata));
            if (exp_we(host_wr, host_addr, host_wdata)) begin
                chk(cfg_addr_o == host_addr && cfg_wdata_o == host_wdata, "R10 forwarded fields",
                    {cfg_addr_o, cfg_wdata_o}, {host_addr, host_wdata});
            end
            @(posedge clk); #1;
            host_wr = 1'b0;
            chk(ready_o == !g, "R6 R7 ready after write", ready_o, !g);
            if (g) begin
                wait_ready(1, n);
                chk(n == INIT + 2, "R6 random sw reset length", n, INIT + 2);
            end
        end

        // Glitches shorter than the minimum width, each width once and random ones.
        for (int w = 1; w < MINL + 6; w++) begin
            int wid;
            wid = (w < MINL) ? w : 1 + ($urandom % (MINL - 1));
            @(negedge clk); rst_pin_n = 1'b0;
            repeat (wid) @(negedge clk);
            rst_pin_n = 1'b1;
            for (int i = 0; i < 12; i++) begin
                @(posedge clk); #1;
                chk(ready_o == 1'b1, "R2 short pulse ignored", ready_o, 1);
            end
        end

        // Pulse of exactly the minimum width, recognised after sync latency.
        @(negedge clk); rst_pin_n = 1'b0;
        n = 0;
        while (n < 5000) begin
            @(posedge clk); #1;
            n++;
            if (n <= STG + MINL)
                chk(ready_o == 1'b1, "R3 sync latency before reset", ready_o, 1);
            if (n == STG + MINL + 1) begin
                chk(ready_o == 1'b0 && in_reset_o == 1'b1, "R1 R3 minimum pulse resets", ready_o, 0);
                check_phase("R1");
            end
            if (n == MINL) begin
                @(negedge clk); rst_pin_n = 1'b1;
            end
            if (n > STG + MINL + 1 && ready_o) break;
        end
        chk(n == MINL + STG + 2 + INIT, "R4 ready after minimum pulse", n, MINL + STG + 2 + INIT);

        // A plain software reset without interference.
        sw_reset(1'b0);
        check_phase("R9 final idle");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule